// File: doc/BRIEF.md
# Gated Programmable Pixel-Clock Divider

The block divides a fast source clock by a selectable ratio and drives a pixel clock whose high and low times are equal at every ratio, odd ones included. Logic on both source-clock edges gives that symmetry and lets a restart land on a half-cycle boundary.

A run starts when the enable input becomes active. A configuration bit sets which level counts as active. The enable is synchronized and edge-detected. The output phase is then realigned, and the first falling edge of the pixel clock follows after a fixed latency that depends on the selected ratio.

When enable goes inactive, the cycle in progress runs to its end and the output then stays high. Enable must stay inactive for at least one output period before it returns. A one-cycle error pulse reports a shorter gap. The ratio select is captured only while the output is parked, so a change during a run waits for the next start.

Top module: `pixclk_div`

## Requirements
- R1: `div_sel_i` selects the output period in source cycles: code 0 gives 3, codes 1 and 2 give 4, code 3 gives 5, code 4 gives 6, codes 5 and 6 give 8, code 7 gives 10, code 8 gives 12, codes 9 and 10 give 16, and code 11 gives 20.
- R2: During a run, the pixel clock is low for exactly half the period and high for exactly half the period. For odd ratios each half is a whole number of source cycles plus one half cycle.
- R3: With `en_pol_i` = 1, enable is active when `en_i` is high. With `en_pol_i` = 0, enable is active when `en_i` is low. The inactive level starts nothing.
- R4: The start edge T0 is the second rising source edge after `en_i` reaches its active level. That edge is the one at which the two-stage synchronizer first reads the input as active. The first falling edge of `pix_clk_o` comes K source cycles after T0. K by code is: 0:2, 1:3.5, 2:3, 3:4.5, 4:3.5, 5:5.5, 6:5, 7:7, 8:6.5, 9:9.5, 10:9, 11:12.
- R5: When enable goes inactive, the low phase in progress completes at full length. The output then rises and stays high, with no further falling edge, until the next start.
- R6: Let G be the number of source cycles between the synchronized deactivation and the synchronized reactivation of enable. If G is less than the output period, `en_err_o` pulses high for exactly one source cycle. If G is equal to or greater than the period, `en_err_o` stays low.
- R7: A change of `div_sel_i` during a run does not change that run's period. The new value takes effect at the next start after the output has parked.
- R8: While `rst_ni` is low, `pix_clk_o` is high and `en_err_o` is low. This also applies when reset is asserted in the middle of a run.
- R9: Codes 12 to 15 behave as code 0: a ratio of 3 and K = 2.
- R10: If enable is reactivated before the output has finished parking, the phase is realigned again. The next falling edge then follows the new T0 by K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock; both edges are used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 4 | Ratio and latency code |
| en_pol_i | input | 1 | Enable level: 1 active high, 0 active low |
| en_i | input | 1 | Asynchronous run enable |
| pix_clk_o | output | 1 | Divided pixel clock, parked high |
| en_err_o | output | 1 | One-cycle pulse on an enable gap shorter than a period |

## Verification
The assertions check the cycle-level invariants on every edge. These are: the output stays high while parked, the cycle counter stays within the active ratio, the select is frozen during a run, a run always opens with the output low, and the error flag never lasts longer than one cycle. Only the directed scenarios can measure edge times. They show the per-code start latency, the half-cycle symmetry at odd ratios, the full-length completion of the last low phase, the polarity inversion, the gap-length boundary of the error flag, and the deferred effect of a ratio change.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
package pixclk_pkg;
  localparam int SEL_W = 4;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} state_e;
  typedef enum logic [1:0] {SH_DIRECT, SH_SHIFT, SH_AND, SH_OR} shape_e;

  // ratio in source cycles, start delay in whole cycles, extra half cycle
  typedef struct packed {
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] delay;
    logic             half;
  } mode_t;

  function automatic mode_t mk_mode(input int r, input int d, input logic h);
    mode_t m;
    m.ratio = CNT_W'(r);
    m.delay = CNT_W'(d);
    m.half  = h;
    return m;
  endfunction

  function automatic mode_t decode(input logic [SEL_W-1:0] s);
    mode_t m;
    case (int'(s))
      1:       m = mk_mode(4, 3, 1'b1);
      2:       m = mk_mode(4, 3, 1'b0);
      3:       m = mk_mode(5, 4, 1'b1);
      4:       m = mk_mode(6, 3, 1'b1);
      5:       m = mk_mode(8, 5, 1'b1);
      6:       m = mk_mode(8, 5, 1'b0);
      7:       m = mk_mode(10, 7, 1'b0);
      8:       m = mk_mode(12, 6, 1'b1);
      9:       m = mk_mode(16, 9, 1'b1);
      10:      m = mk_mode(16, 9, 1'b0);
      11:      m = mk_mode(20, 12, 1'b0);
      default: m = mk_mode(3, 2, 1'b0);
    endcase
    return m;
  endfunction

  // cycles the posedge waveform stays low after a fall
  function automatic logic [CNT_W-1:0] low_len(input mode_t m);
    logic [CNT_W-1:0] h;
    h = m.ratio >> 1;
    if (m.ratio[0] && m.half) h = h + CNT_W'(1);
    return h;
  endfunction

  function automatic shape_e shape_of(input mode_t m);
    if (m.ratio[0]) return m.half ? SH_OR : SH_AND;
    return m.half ? SH_SHIFT : SH_DIRECT;
  endfunction
endpackage

// File: rtl/pixclk_sync.sv
`timescale 1ns/1ps
module pixclk_sync #(
  parameter int STAGES = 2,
  parameter int OFF_W  = 5,
  parameter int CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             err_o
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;
  localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);

  logic [STAGES-1:0] sh_q;
  logic              last_q;
  logic [OFF_W-1:0]  off_q;
  logic              err_q;
  logic              act;
  logic              short_gap;

  assign act       = en_i ~^ pol_i;
  assign lvl_o     = sh_q[STAGES-1];
  assign rise_o    = lvl_o & ~last_q;
  assign short_gap = OFF_W'(off_q) < OFF_W'(ratio_i);
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
      off_q  <= OFF_MAX;
      err_q  <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], act};
      last_q <= lvl_o;
      if (lvl_o)               off_q <= '0;
      else if (off_q != OFF_MAX) off_q <= off_q + OFF_ONE;
      err_q  <= rise_o & short_gap;
    end
  end
endmodule

// File: rtl/pixclk_seq.sv
`timescale 1ns/1ps
module pixclk_seq
  import pixclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             lvl_i,
  input  logic             rise_i,
  output logic             wave_o,
  output shape_e           shape_o,
  output state_e           st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic [SEL_W-1:0] sel_q_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  state_e           st_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q, dly_q, cnt_nx, lo;
  logic [SEL_W-1:0] sel_eff;
  logic             wave_q, wrap;
  mode_t            m;

  // select is live only while parked
  assign sel_eff = (st_q == ST_IDLE) ? sel_i : sel_q;
  assign m       = decode(sel_eff);
  assign lo      = low_len(m);
  assign wrap    = (cnt_q == m.ratio - ONE);
  assign cnt_nx  = wrap ? '0 : cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      cnt_q  <= '0;
      dly_q  <= '0;
      wave_q <= 1'b1;
    end else begin
      sel_q <= sel_eff;
      if (rise_i) begin
        st_q   <= ST_WAIT;
        dly_q  <= m.delay - TWO;
        cnt_q  <= '0;
        wave_q <= 1'b1;
      end else begin
        case (st_q)
          ST_WAIT: begin
            if (dly_q == '0) begin
              st_q   <= ST_RUN;
              cnt_q  <= '0;
              wave_q <= 1'b0;
            end else begin
              dly_q <= dly_q - ONE;
            end
          end
          ST_RUN: begin
            if (wrap && !lvl_i) begin
              st_q   <= ST_IDLE;
              cnt_q  <= '0;
              wave_q <= 1'b1;
            end else begin
              cnt_q  <= cnt_nx;
              wave_q <= (cnt_nx >= lo);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wave_o  = wave_q;
  assign shape_o = shape_of(m);
  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign ratio_o = m.ratio;
  assign sel_q_o = sel_q;
endmodule

// File: rtl/pixclk_shape.sv
`timescale 1ns/1ps
module pixclk_shape
  import pixclk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wave_i,
  input  shape_e shape_i,
  output logic   clk_o
);
  logic wave_n_q;

  // half-cycle delayed copy
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_n_q <= 1'b1;
    else         wave_n_q <= wave_i;
  end

  always_comb begin
    case (shape_i)
      SH_SHIFT: clk_o = wave_n_q;
      SH_AND:   clk_o = wave_i & wave_n_q;
      SH_OR:    clk_o = wave_i | wave_n_q;
      default:  clk_o = wave_i;
    endcase
  end
endmodule

// File: rtl/pixclk_div.sv
`timescale 1ns/1ps
module pixclk_div
  import pixclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OFF_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             en_pol_i,
  input  logic             en_i,
  output logic             pix_clk_o,
  output logic             en_err_o
);
  logic             lvl, rise, wave;
  shape_e           shape;
  state_e           st_w;
  logic [CNT_W-1:0] cnt_w, ratio_w;
  logic [SEL_W-1:0] sel_q_w;

  pixclk_sync #(
    .STAGES(SYNC_STAGES),
    .OFF_W (OFF_W),
    .CNT_W (CNT_W)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .pol_i  (en_pol_i),
    .ratio_i(ratio_w),
    .lvl_o  (lvl),
    .rise_o (rise),
    .err_o  (en_err_o)
  );

  pixclk_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (div_sel_i),
    .lvl_i  (lvl),
    .rise_i (rise),
    .wave_o (wave),
    .shape_o(shape),
    .st_o   (st_w),
    .cnt_o  (cnt_w),
    .ratio_o(ratio_w),
    .sel_q_o(sel_q_w)
  );

  pixclk_shape u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wave_i (wave),
    .shape_i(shape),
    .clk_o  (pix_clk_o)
  );
endmodule

// File: rtl/pixclk_div_chk.sv
`timescale 1ns/1ps
module pixclk_div_chk
  import pixclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_clk_o,
  input logic             en_err_o,
  input state_e           st_i,
  input logic             wave_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] ratio_i,
  input logic [SEL_W-1:0] sel_q_i
);
  AST_PARK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && $past(st_i) == ST_IDLE) |-> pix_clk_o); // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN) |-> (cnt_i < ratio_i)); // R1

  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_IDLE && $past(st_i) != ST_IDLE) |-> $stable(sel_q_i)); // R7

  AST_RUN_OPENS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && $past(st_i) == ST_WAIT) |-> !wave_i); // R4

  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_err_o |=> !en_err_o); // R6
endmodule

bind pixclk_div pixclk_div_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_clk_o(pix_clk_o),
  .en_err_o (en_err_o),
  .st_i     (st_w),
  .wave_i   (wave),
  .cnt_i    (cnt_w),
  .ratio_i  (ratio_w),
  .sel_q_i  (sel_q_w)
);

// File: tb/sim_pixclk_div.sv
`timescale 1ns/1ps
module sim_pixclk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] div_sel_i = 4'd0;
  logic       en_pol_i = 1'b1;
  logic       en_i = 1'b0;
  logic       pix_clk_o, en_err_o;

  int n_chk = 0, n_err = 0, falls = 0, errs = 0;

  pixclk_div u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .en_pol_i (en_pol_i),
    .en_i     (en_i),
    .pix_clk_o(pix_clk_o),
    .en_err_o (en_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(negedge pix_clk_o) if (rst_ni) falls++;
  always @(negedge clk_i) if (rst_ni && en_err_o) errs++;

  // R1 ratio table
  function automatic int ratio_of(input int c);
    case (c)
      1, 2: return 4;   3: return 5;   4: return 6;
      5, 6: return 8;   7: return 10;  8: return 12;
      9, 10: return 16; 11: return 20;
      default: return 3;
    endcase
  endfunction

  // R4 latency in half source cycles
  function automatic int khalf_of(input int c);
    case (c)
      1: return 7;  2: return 6;  3: return 9;  4: return 7;
      5: return 11; 6: return 10; 7: return 14; 8: return 13;
      9: return 19; 10: return 18; 11: return 24;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string what, input real act, input real exp);
    n_chk++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_err++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", what, act, exp);
    end
  endtask

  task automatic set_en(input bit act);
    en_i = en_pol_i ? act : ~act;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // one full start / measure / park sequence
  task automatic t_mode(input int code, input int eff, output real per);
    real td, tf1, tr, tf2, tr2;
    int  f0, e0;
    real hn;
    hn = ratio_of(eff) * 2.5;
    e0 = errs;
    @(negedge clk_i); div_sel_i = 4'(code);
    @(negedge clk_i); set_en(1); td = $realtime;
    @(negedge pix_clk_o); tf1 = $realtime;
    chk($sformatf("R4 start latency code %0d", code), tf1 - td, 7.5 + khalf_of(eff) * 2.5);
    @(posedge pix_clk_o); tr = $realtime;
    chk($sformatf("R2 low time code %0d", code), tr - tf1, hn);
    @(negedge pix_clk_o); tf2 = $realtime;
    chk($sformatf("R2 high time code %0d", code), tf2 - tr, hn);
    per = tf2 - tf1;
    chk($sformatf("R1 period code %0d", code), per, ratio_of(eff) * 5.0);
    @(negedge clk_i); set_en(0); f0 = falls;
    @(posedge pix_clk_o); tr2 = $realtime;
    chk($sformatf("R5 last low completes code %0d", code), tr2 - tf2, hn);
    repeat (4 * ratio_of(eff)) @(negedge clk_i);
    chk($sformatf("R5 no fall after stop code %0d", code), falls - f0, 0);
    chk($sformatf("R5 parked high code %0d", code), pix_clk_o, 1);
    chk($sformatf("R6 no flag on long gap code %0d", code), errs - e0, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk_i);
    chk("R8 output high in reset", pix_clk_o, 1);
    chk("R8 flag low in reset", en_err_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R8 output high after release", pix_clk_o, 1);
  endtask

  task automatic t_all_codes();
    real p;
    for (int c = 0; c < 12; c++) t_mode(c, c, p);
  endtask

  task automatic t_reserved();
    real p;
    for (int c = 12; c < 16; c += 3) begin
      t_mode(c, 0, p);
      chk($sformatf("R9 reserved code %0d period", c), p, 15.0);
    end
  endtask

  task automatic t_polarity();
    real td, tf;
    int  f0;
    @(negedge clk_i); en_pol_i = 1'b0; en_i = 1'b1; div_sel_i = 4'd7;
    f0 = falls;
    repeat (30) @(negedge clk_i);
    chk("R3 high level inactive with polarity 0", falls - f0, 0);
    en_i = 1'b0; td = $realtime;
    @(negedge pix_clk_o); tf = $realtime;
    chk("R3 low level starts with polarity 0", tf - td, 7.5 + 14 * 2.5);
    @(negedge clk_i); en_i = 1'b1;
    repeat (60) @(negedge clk_i);
    f0 = falls;
    repeat (30) @(negedge clk_i);
    chk("R3 high level stops with polarity 0", falls - f0, 0);
    chk("R3 parked high with polarity 0", pix_clk_o, 1);
    @(negedge clk_i); en_pol_i = 1'b1; en_i = 1'b0;
    repeat (30) @(negedge clk_i);
  endtask

  task automatic t_sel_hold();
    real tf1, tf2, td;
    @(negedge clk_i); div_sel_i = 4'd2;
    @(negedge clk_i); set_en(1);
    @(negedge pix_clk_o); tf1 = $realtime;
    @(negedge clk_i); div_sel_i = 4'd11;
    @(negedge pix_clk_o); tf2 = $realtime;
    chk("R7 period unchanged mid-run", tf2 - tf1, 20.0);
    @(negedge clk_i); set_en(0);
    repeat (30) @(negedge clk_i);
    set_en(1); td = $realtime;
    @(negedge pix_clk_o); tf1 = $realtime;
    chk("R7 new code latency after park", tf1 - td, 7.5 + 24 * 2.5);
    @(negedge pix_clk_o); tf2 = $realtime;
    chk("R7 new code period after park", tf2 - tf1, 100.0);
    @(negedge clk_i); set_en(0);
    repeat (120) @(negedge clk_i);
  endtask

  // gap in cycles between deactivation and reactivation, code 2 (period 4)
  task automatic t_gap(input int gap, input int exp_err);
    real td, tf;
    int  e0;
    @(negedge clk_i); div_sel_i = 4'd2;
    @(negedge clk_i); set_en(1);
    @(negedge pix_clk_o);
    @(negedge clk_i); set_en(0); e0 = errs;
    repeat (gap) @(negedge clk_i);
    set_en(1); td = $realtime;
    repeat (4) @(negedge clk_i);
    chk($sformatf("R6 flag pulses for gap %0d", gap), errs - e0, exp_err);
    @(negedge pix_clk_o); tf = $realtime;
    chk($sformatf("R10 realigned start after gap %0d", gap), tf - td, 7.5 + 6 * 2.5);
    @(negedge clk_i); set_en(0);
    repeat (40) @(negedge clk_i);
  endtask

  task automatic t_reset_mid_run();
    @(negedge clk_i); div_sel_i = 4'd7;
    @(negedge clk_i); set_en(1);
    @(negedge pix_clk_o);
    #1 rst_ni = 1'b0; set_en(0);
    #1 chk("R8 reset mid-run forces output high", pix_clk_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R8 flag low during reset", en_err_o, 0);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk_i);
    chk("R8 stays parked after reset", pix_clk_o, 1);
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_all_codes();
    t_reserved();
    t_polarity();
    t_sel_hold();
    t_gap(2, 1);
    t_gap(3, 1);
    t_gap(4, 0);
    t_reset_mid_run();
    finish_run();
  end
endmodule